// File: doc/BRIEF.md
# Sample Stream Debug Counter and Timestamp

This block sits in a receive sample path, between the source of complex baseband samples and the interface that carries them to the host. Each sample is a 32-bit word: a 16-bit in-phase half in the low bits and a 16-bit quadrature half in the high bits. Samples move under a valid/ready handshake. The block is combinational for data and handshake and adds no cycle of latency.

A 32-bit configuration word controls the block. When the debug-count bit is set, every outgoing sample word is replaced by a 32-bit sequence number. The host can then check for gaps to find dropped samples. The sequence number counts every sample accepted downstream since reset.

The block also keeps a 64-bit timestamp of accepted samples. By default it counts the in-phase and quadrature halves separately, so it advances by two per sample. A divide-by-two bit makes it advance by one per sample instead. When the timestamp-enable bit is clear, the timestamp freezes at its current value.

Top module: `sample_dbg_stamp`

## Requirements
- R1: After a synchronous reset, the sequence number and the timestamp are both 0. A reset issued in the middle of a run clears both again.
- R2: With configuration bit 9 at 0, `dst_data` equals `src_data` in the same cycle.
- R3: With configuration bit 9 at 1, `dst_data` carries the sequence number in little-endian byte order: its least significant byte is in bits [7:0]. The first accepted sample after reset carries 0.
- R4: The sequence number advances by exactly one in each cycle where `dst_valid` and `dst_ready` are both 1, and in no other cycle. This holds whichever value bit 9 has.
- R5: `dst_valid` follows `src_valid` and `src_ready` follows `dst_ready` in the same cycle.
- R6: While a word is stalled (`dst_valid` high, `dst_ready` low), a change of bit 9 does not take effect. The mode in force when the stall began is kept until that word is accepted, so no word switches between sample data and count data.
- R7: With configuration bit 16 at 0, `tstamp` holds its value.
- R8: With bit 16 at 1 and bit 17 at 0, `tstamp` rises by 2 on each accepted sample. It rises by 0 in other cycles and wraps modulo 2^64.
- R9: With bits 16 and 17 both at 1, `tstamp` rises by exactly 1 on each accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration: bit 9 debug count, bit 16 timestamp enable, bit 17 timestamp halve |
| src_valid | input | 1 | Sample offered by the radio side |
| src_data | input | 32 | Sample word: in-phase in bits [15:0], quadrature in bits [31:16] |
| src_ready | output | 1 | Block can take the offered sample |
| dst_valid | output | 1 | Sample offered toward the host |
| dst_data | output | 32 | Sample word or sequence number |
| dst_ready | input | 1 | Host side accepts the sample |
| tstamp | output | 64 | Sample timestamp |

## Verification
The bench flips bit 9 on every cycle while holding `dst_ready` low for long stretches. A design that read the mode live would then change a stalled word from sample data to a count. The bench stalls with `src_valid` high, so a counter that advanced on valid alone, or on ready alone, would skip or repeat sequence numbers. The bench switches bit 17 and bit 16 in separate phases, which exposes a wrong step size or a timestamp that keeps running while disabled. A mid-run reset checks that both counters return to 0 and not to some held value.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int SAMPLE_W    = 16;
    localparam int WORD_W      = 2 * SAMPLE_W;
    localparam int CFG_W       = 32;
    localparam int STAMP_W     = 64;

    // Bit positions inside the configuration word
    localparam int CFG_COUNT_BIT  = 9;
    localparam int CFG_TS_EN_BIT  = 16;
    localparam int CFG_TS_HALF_BIT = 17;

    typedef struct packed {
        logic ts_half;
        logic ts_en;
        logic count_mode;
    } ctrl_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] quad;
        logic [SAMPLE_W-1:0] inph;
    } iq_word_t;

    function automatic ctrl_t decode_ctrl(input logic [CFG_W-1:0] w);
        ctrl_t c;
        c.count_mode = w[CFG_COUNT_BIT];
        c.ts_en      = w[CFG_TS_EN_BIT];
        c.ts_half    = w[CFG_TS_HALF_BIT];
        return c;
    endfunction

    // Counts added per accepted sample: one per half, or one per sample
    function automatic logic [1:0] stamp_step(input logic half);
        return half ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/sdc_step_counter.sv
module sdc_step_counter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic [1:0]       step,
    output logic [WIDTH-1:0] value
);

    logic [WIDTH-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst)
            value_q <= '0;
        else if (inc)
            value_q <= value_q + WIDTH'(step);
    end

    assign value = value_q;

    // R4 R8 R9
    counter_step_chk: assert property (@(posedge clk) disable iff (rst)
        inc |=> value == $past(value) + WIDTH'($past(step)));

    // R4 R7
    counter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(value));

endmodule

// File: rtl/sdc_mode_hold.sv
module sdc_mode_hold (
    input  logic clk,
    input  logic rst,
    input  logic req_mode,
    input  logic stalled,
    output logic mode
);

    logic stall_q;
    logic mode_q;

    // A word that was offered but not taken keeps the mode it was built with
    assign mode = stall_q ? mode_q : req_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            stall_q <= stalled;
            mode_q  <= mode;
        end
    end

    // R6
    mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        stalled |=> mode == $past(mode));

endmodule

// File: rtl/sample_dbg_stamp.sv
module sample_dbg_stamp
    import sdc_pkg::*;
#(
    parameter int SEQ_W = WORD_W,
    parameter int TS_W  = STAMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              src_valid,
    input  logic [WORD_W-1:0] src_data,
    output logic              src_ready,
    output logic              dst_valid,
    output logic [WORD_W-1:0] dst_data,
    input  logic              dst_ready,
    output logic [TS_W-1:0]   tstamp
);

    localparam int NBYTES = WORD_W / 8;

    ctrl_t            ctrl;
    logic             accept;
    logic             stalled;
    logic             mode;
    logic [SEQ_W-1:0] seq;
    iq_word_t         pass_word;
    logic [WORD_W-1:0] seq_word;

    assign ctrl      = decode_ctrl(cfg_word);
    assign dst_valid = src_valid;
    assign src_ready = dst_ready;
    assign accept    = src_valid && dst_ready;
    assign stalled   = src_valid && !dst_ready;
    assign pass_word = iq_word_t'(src_data);

    sdc_mode_hold u_mode (
        .clk      (clk),
        .rst      (rst),
        .req_mode (ctrl.count_mode),
        .stalled  (stalled),
        .mode     (mode)
    );

    sdc_step_counter #(.WIDTH(SEQ_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .inc   (accept),
        .step  (2'd1),
        .value (seq)
    );

    sdc_step_counter #(.WIDTH(TS_W)) u_stamp (
        .clk   (clk),
        .rst   (rst),
        .inc   (accept && ctrl.ts_en),
        .step  (stamp_step(ctrl.ts_half)),
        .value (tstamp)
    );

    // Least significant byte of the sequence number goes to the lowest lane
    for (genvar b = 0; b < NBYTES; b++) begin : g_le_lane
        assign seq_word[8*b +: 8] = (8*b < SEQ_W) ? seq[8*b +: 8] : 8'h00;
    end

    assign dst_data = mode ? seq_word : WORD_W'(pass_word);

    // R6
    stall_word_chk: assert property (@(posedge clk) disable iff (rst)
        (stalled && mode) |=> $stable(dst_data));

    // R7
    stamp_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.ts_en |=> $stable(tstamp));

endmodule

// File: tb/test_sample_dbg_stamp.sv
module test_sample_dbg_stamp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        src_valid = 1'b0;
    logic [31:0] src_data = '0;
    logic        src_ready;
    logic        dst_valid;
    logic [31:0] dst_data;
    logic        dst_ready = 1'b0;
    logic [63:0] tstamp;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    longint unsigned m_seq = 0;
    longint unsigned m_ts = 0;
    bit m_stall = 0;
    bit m_held = 0;

    always #10 clk = ~clk;

    sample_dbg_stamp i_sample_dbg_stamp (
        .clk(clk), .rst(rst), .cfg_word(cfg_word),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .dst_valid(dst_valid), .dst_data(dst_data), .dst_ready(dst_ready),
        .tstamp(tstamp)
    );

    task automatic check(input string tag, input longint unsigned got, input longint unsigned exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; src_valid = 1'b0; dst_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_seq = 0; m_ts = 0; m_stall = 0; m_held = 0;
    endtask

    // One cycle: drive, compare with model, update model at the edge
    task automatic step_cycle(input bit [31:0] cfg, input bit v, input bit r,
                              input string dtag, input string ttag);
        bit mode;
        bit [31:0] exp_d;
        cfg_word = cfg; src_valid = v; dst_ready = r; src_data = $urandom;
        #2;
        mode = m_stall ? m_held : cfg[9];
        exp_d = mode ? 32'(m_seq) : src_data;
        check("R5 dst_valid", dst_valid, v);
        check("R5 src_ready", src_ready, r);
        if (v) check(dtag, dst_data, exp_d);
        check(ttag, tstamp, m_ts);
        @(posedge clk);
        if (v && r) begin
            m_seq = (m_seq + 1) & 64'hFFFF_FFFF;
            if (cfg[16]) m_ts = m_ts + (cfg[17] ? 1 : 2);
        end
        m_stall = v && !r;
        m_held = mode;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        #2;
        // R1 reset state
        check("R1 tstamp after reset", tstamp, 0);
        cfg_word = 32'h0000_0200; src_valid = 1'b1;
        #1;
        check("R1 sequence after reset", dst_data, 0);
        src_valid = 1'b0;
        @(negedge clk);

        // R2 pass-through, timestamp disabled (R7)
        for (int k = 0; k < 200; k++)
            step_cycle(32'h0000_0000, $urandom_range(0,1), $urandom_range(0,1), "R2 passthru", "R7 ts hold");

        // R3/R4 counting mode, random handshake
        for (int k = 0; k < 300; k++)
            step_cycle(32'h0000_0200, $urandom_range(0,3) != 0, $urandom_range(0,2) != 0, "R3 R4 seq word", "R7 ts hold");

        // R8 timestamp counts two per sample
        for (int k = 0; k < 300; k++)
            step_cycle(32'h0001_0000 | ($urandom_range(0,1) << 9), $urandom_range(0,1), $urandom_range(0,1), "R2 R3 data", "R8 ts by two");

        // R9 timestamp counts one per sample
        for (int k = 0; k < 300; k++)
            step_cycle(32'h0003_0200, $urandom_range(0,1), $urandom_range(0,1), "R3 data", "R9 ts by one");

        // R6 mode toggling during long stalls
        for (int k = 0; k < 600; k++)
            step_cycle({14'h0, 2'b01, 6'h0, 1'($urandom_range(0,1)), 9'h0},
                       1'b1, $urandom_range(0,4) == 0, "R6 stall mode hold", "R8 ts by two");

        // R7 disabled timestamp holds a nonzero value
        for (int k = 0; k < 200; k++)
            step_cycle(32'h0002_0200, $urandom_range(0,1), $urandom_range(0,1), "R4 seq word", "R7 ts hold");

        // R1 mid-run reset
        do_reset();
        #2;
        check("R1 tstamp after mid reset", tstamp, 0);
        for (int k = 0; k < 100; k++)
            step_cycle(32'h0001_0200, $urandom_range(0,1), $urandom_range(0,1), "R1 R3 seq restart", "R8 ts by two");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule